// File: doc/BRIEF.md
# Programmable Error Injection Unit

This block sits inline on a datapath that carries parity- or ECC-protected words. On command it inverts one chosen bit of a passing word, or optionally two chosen bits, for that single word only. Downstream checkers, correctors and error counters can then be exercised on live traffic. The flip path is combinational, so a word leaves the block in the same cycle it arrives and the datapath latency does not change.

A service controller programs the unit through a small register port. The unit has two modes. In one-shot mode it corrupts the first valid word after arming, then disarms itself and raises a done flag. In periodic mode it corrupts one valid word out of every interval-plus-one valid words until it is disabled, so that threshold logic downstream sees a steady error stream. A saturating tally of performed injections can be read back and compared with the error counts that the checkers report.

Top module: `fault_inject_unit`

## Requirements
- R1: After reset the unit is disabled, every register reads zero, and `out_data` equals `in_data`.
- R2: `out_valid` always equals `in_valid`. On cycles with `in_valid` low, `out_data` equals `in_data` and `inj_fire` is low. Without an injection, every word passes unchanged.
- R3: Writing CTRL with enable=1 and periodic=0 arms a one-shot. The first cycle with `in_valid` high that follows the write has bit idx_a inverted, and later words pass clean. At that edge, STATUS bit 1 (armed) clears and STATUS bit 0 (done) sets. Any CTRL write clears done.
- R4: With enable=1 and periodic=1 and an interval N, the N valid words after the CTRL write pass clean and the next valid word is corrupted. The pattern then repeats. Cycles with `in_valid` low do not advance the interval.
- R5: An interval of 0 in periodic mode corrupts every valid word.
- R6: Writing CTRL with enable=0 stops all injection from the next cycle on, and `inj_fire` stays low.
- R7: When CTRL bit 2 (second-bit enable) is set, an injection also inverts bit idx_b in the same word. When idx_b equals idx_a, only that one bit is inverted.
- R8: An index of DATA_W or more selects no bit. Such an injection still raises `inj_fire` and is still counted.
- R9: STATUS bits [16 +: CNT_W] hold the number of injections, which saturates at 2^CNT_W-1. Any write to STATUS clears the count and done.
- R10: Register map (2-bit address): 0 is CTRL, with bit 0 enable, bit 1 periodic and bit 2 second-bit enable. 1 is SEL, with bits [7:0] idx_a and [15:8] idx_b. 2 is INTERVAL, bits [IVL_W-1:0]. 3 is STATUS. Each writable field reads back the value written, and `cfg_rdata` follows `cfg_addr` combinationally.
- R11: `inj_fire` is high exactly on the cycles in which an injection occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe from the service controller |
| cfg_addr | input | 2 | Register address for writes and reads |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| in_valid | input | 1 | Incoming word is valid |
| in_data | input | DATA_W | Incoming protected word (data and check bits) |
| out_valid | output | 1 | Outgoing word is valid |
| out_data | output | DATA_W | Outgoing word, possibly with one or two bits inverted |
| inj_fire | output | 1 | An injection occurs this cycle |

## Verification
The assertions assume that the service controller does not write STATUS in the same cycle as an injection whose count increment is being checked. Their antecedents exclude such cycles. They also assume that idx_a and idx_b stay below 256, which the 8-bit fields guarantee.

The stimulus changes configuration only through single-cycle register writes. It interleaves these writes with valid and idle data cycles, and it reaches index values past DATA_W, equal index pairs and counter saturation through a reduced CNT_W.

// File: rtl/fij_pkg.sv
`timescale 1ns/1ps
// Shared register addresses, field positions and configuration type for
// the error injection unit. Assumes a 2-bit register address space.
package fij_pkg;
    localparam int REG_AW = 2;
    localparam int REG_DW = 32;
    localparam int IDX_W  = 8;

    typedef enum logic [REG_AW-1:0] {
        A_CTRL = 2'd0,
        A_SEL  = 2'd1,
        A_IVL  = 2'd2,
        A_STAT = 2'd3
    } reg_addr_e;

    localparam int CTRL_EN      = 0;
    localparam int CTRL_PER     = 1;
    localparam int CTRL_DBL     = 2;
    localparam int SEL_A_LSB    = 0;
    localparam int SEL_B_LSB    = 8;
    localparam int STAT_DONE    = 0;
    localparam int STAT_ARMED   = 1;
    localparam int STAT_CNT_LSB = 16;

    typedef struct packed {
        logic             en;
        logic             periodic;
        logic             dbl;
        logic [IDX_W-1:0] idx_a;
        logic [IDX_W-1:0] idx_b;
    } inj_cfg_t;
endpackage

// File: rtl/fij_regs.sv
`timescale 1ns/1ps
// Configuration registers and read mux. Decodes single-cycle writes into
// config state and the strobes that other parts act on. Assumes
// IVL_W <= 16 and CNT_W <= 16.
module fij_regs
    import fij_pkg::*;
#(
    parameter int IVL_W = 16,
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [REG_AW-1:0]       addr,
    input  logic [REG_DW-1:0]       wdata,
    input  logic                    armed,
    input  logic                    done,
    input  logic [CNT_W-1:0]        count,
    output inj_cfg_t                cfg,
    output logic [IVL_W-1:0]        ivl,
    output logic                    ctrl_wr,
    output logic                    arm_set,
    output logic                    stat_clr,
    output logic [REG_DW-1:0]       rdata
);
    logic unused_wdata;
    assign unused_wdata = ^wdata[REG_DW-1:STAT_CNT_LSB];

    // Write strobes decoded from the register port.
    assign ctrl_wr  = we && (reg_addr_e'(addr) == A_CTRL);
    assign stat_clr = we && (reg_addr_e'(addr) == A_STAT);
    assign arm_set  = ctrl_wr && wdata[CTRL_EN] && !wdata[CTRL_PER];

    // Hold configuration fields written by the service controller.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
            ivl <= '0;
        end else if (we) begin
            case (reg_addr_e'(addr))
                A_CTRL: begin
                    cfg.en       <= wdata[CTRL_EN];
                    cfg.periodic <= wdata[CTRL_PER];
                    cfg.dbl      <= wdata[CTRL_DBL];
                end
                A_SEL: begin
                    cfg.idx_a <= wdata[SEL_A_LSB +: IDX_W];
                    cfg.idx_b <= wdata[SEL_B_LSB +: IDX_W];
                end
                A_IVL:   ivl <= wdata[IVL_W-1:0];
                default: ;
            endcase
        end
    end

    // Select the register addressed for read.
    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            A_CTRL: begin
                rdata[CTRL_EN]  = cfg.en;
                rdata[CTRL_PER] = cfg.periodic;
                rdata[CTRL_DBL] = cfg.dbl;
            end
            A_SEL: begin
                rdata[SEL_A_LSB +: IDX_W] = cfg.idx_a;
                rdata[SEL_B_LSB +: IDX_W] = cfg.idx_b;
            end
            A_IVL: rdata[IVL_W-1:0] = ivl;
            A_STAT: begin
                rdata[STAT_DONE]              = done;
                rdata[STAT_ARMED]             = armed;
                rdata[STAT_CNT_LSB +: CNT_W]  = count;
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/fij_sched.sv
`timescale 1ns/1ps
// Decides on which valid word an injection happens. One-shot: an armed
// flag set by a CTRL write and cleared by the hit. Periodic: a counter of
// clean valid words compared with the interval. Assumes config is stable
// between register writes.
module fij_sched #(
    parameter int IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             periodic,
    input  logic [IVL_W-1:0] ivl,
    input  logic             ctrl_wr,
    input  logic             arm_set,
    input  logic             in_valid,
    output logic             fire,
    output logic             os_hit,
    output logic             armed
);
    logic [IVL_W-1:0] gap_q;
    logic             pr_hit;
    logic             pr_step;

    // Hit decisions for the two modes on the current word.
    assign os_hit  = in_valid && en && !periodic && armed;
    assign pr_step = in_valid && en && periodic;
    assign pr_hit  = pr_step && (gap_q >= ivl);
    assign fire    = os_hit || pr_hit;

    // One-shot arming: set by the arming write, dropped after the hit.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed <= 1'b0;
        else if (ctrl_wr) armed <= arm_set;
        else if (os_hit)  armed <= 1'b0;
    end

    // Count clean valid words between periodic injections.
    always_ff @(posedge clk) begin
        if (!rst_n)       gap_q <= '0;
        else if (ctrl_wr) gap_q <= '0;
        else if (pr_step) gap_q <= pr_hit ? '0 : gap_q + 1'b1;
    end
endmodule

// File: rtl/fij_flip.sv
`timescale 1ns/1ps
// Builds the flip mask from one or two bit indices and applies it to the
// passing word. Indices outside the word select nothing. Assumes
// DATA_W <= 256 so that every bit is reachable by an 8-bit index.
module fij_flip
    import fij_pkg::*;
#(
    parameter int DATA_W = 72
) (
    input  logic              fire,
    input  logic              dbl,
    input  logic [IDX_W-1:0]  idx_a,
    input  logic [IDX_W-1:0]  idx_b,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] out_data
);
    logic [DATA_W-1:0] mask;

    // One decoder term per bit; the two selects are ORed, never XORed.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign mask[i] = (idx_a == IDX_W'(i)) || (dbl && (idx_b == IDX_W'(i)));
    end

    // Apply the mask only on an injection cycle.
    assign out_data = fire ? (in_data ^ mask) : in_data;
endmodule

// File: rtl/fij_tally.sv
`timescale 1ns/1ps
// Saturating injection count and one-shot done flag. Clears take
// priority over updates in the same cycle.
module fij_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             os_hit,
    input  logic             ctrl_wr,
    input  logic             stat_clr,
    output logic [CNT_W-1:0] count,
    output logic             done
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count injections, stopping at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)                       count <= '0;
        else if (stat_clr)                count <= '0;
        else if (fire && count != CNT_MAX) count <= count + 1'b1;
    end

    // Record completion of a one-shot.
    always_ff @(posedge clk) begin
        if (!rst_n)                 done <= 1'b0;
        else if (stat_clr || ctrl_wr) done <= 1'b0;
        else if (os_hit)            done <= 1'b1;
    end
endmodule

// File: rtl/fault_inject_unit.sv
`timescale 1ns/1ps
// Inline error injection unit for a protected datapath. Inverts one or two
// programmed bits of a valid word in one-shot or periodic mode. The data
// path is combinational (zero latency). Assumes the register port is
// driven only by the service controller.
module fault_inject_unit
    import fij_pkg::*;
#(
    parameter int DATA_W = 72,
    parameter int IVL_W  = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              inj_fire
);
    inj_cfg_t         cfg_q;
    logic [IVL_W-1:0] ivl_q;
    logic             ctrl_wr, arm_set, stat_clr;
    logic             fire, os_hit, armed, done;
    logic [CNT_W-1:0] count;

    fij_regs #(.IVL_W(IVL_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .armed(armed), .done(done), .count(count),
        .cfg(cfg_q), .ivl(ivl_q), .ctrl_wr(ctrl_wr), .arm_set(arm_set),
        .stat_clr(stat_clr), .rdata(cfg_rdata)
    );

    fij_sched #(.IVL_W(IVL_W)) u_sched (
        .clk(clk), .rst_n(rst_n), .en(cfg_q.en), .periodic(cfg_q.periodic),
        .ivl(ivl_q), .ctrl_wr(ctrl_wr), .arm_set(arm_set),
        .in_valid(in_valid), .fire(fire), .os_hit(os_hit), .armed(armed)
    );

    fij_flip #(.DATA_W(DATA_W)) u_flip (
        .fire(fire), .dbl(cfg_q.dbl), .idx_a(cfg_q.idx_a),
        .idx_b(cfg_q.idx_b), .in_data(in_data), .out_data(out_data)
    );

    fij_tally #(.CNT_W(CNT_W)) u_tally (
        .clk(clk), .rst_n(rst_n), .fire(fire), .os_hit(os_hit),
        .ctrl_wr(ctrl_wr), .stat_clr(stat_clr), .count(count), .done(done)
    );

    assign out_valid = in_valid;
    assign inj_fire  = fire;
endmodule

// File: rtl/fij_checker.sv
`timescale 1ns/1ps
// Property checker for the error injection unit, bound to the top module.
module fij_checker #(
    parameter int DATA_W = 72,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [1:0]        cfg_addr,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic [DATA_W-1:0] out_data,
    input logic              inj_fire,
    input logic              en,
    input logic              periodic,
    input logic              dbl,
    input logic              armed,
    input logic              done,
    input logic [CNT_W-1:0]  count
);
    localparam logic [CNT_W-1:0] CMAX = '1;
    logic stat_wr;
    assign stat_wr = cfg_we && (cfg_addr == 2'd3);

    p_idle_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (out_data == in_data && !inj_fire));

    p_oneshot_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_fire && !periodic && !cfg_we) |=> (done && !armed));

    p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !inj_fire);

    p_flip_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(out_data ^ in_data) <= (dbl ? 2 : 1));

    p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CMAX && !stat_wr) |=> count == CMAX);

    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_fire && count != CMAX && !stat_wr) |=> count == $past(count) + 1'b1);

    p_clean_without_fire_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !inj_fire |-> out_data == in_data);
endmodule

bind fault_inject_unit fij_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .in_valid(in_valid), .in_data(in_data), .out_data(out_data),
    .inj_fire(inj_fire), .en(cfg_q.en), .periodic(cfg_q.periodic),
    .dbl(cfg_q.dbl), .armed(armed), .done(done), .count(count)
);

// File: tb/fault_inject_unit_test.sv
`timescale 1ns/1ps
module fault_inject_unit_test;
    localparam int DW = 72;
    localparam int IW = 16;
    localparam int CW = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = 2'd3;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          inj_fire;

    always #2 clk = ~clk;

    fault_inject_unit #(.DATA_W(DW), .IVL_W(IW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
        .inj_fire(inj_fire)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // Behavioural reference state.
    bit m_en, m_per, m_dbl, m_armed, m_done;
    int m_ia, m_ib, m_ivl, m_gap, m_cnt;

    task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One clock cycle: drive, compare against the model, then advance it.
    task automatic step(bit v, bit we, logic [1:0] a, logic [31:0] wd, string tag);
        logic [DW-1:0] d, exp_d;
        logic [31:0]   exp_r;
        bit            f;
        @(negedge clk);
        d = {$urandom, $urandom, $urandom};
        in_valid = v; in_data = d; cfg_we = we; cfg_addr = a; cfg_wdata = wd;
        #1;
        f = v && m_en && ((!m_per && m_armed) || (m_per && m_gap >= m_ivl));
        exp_d = d;
        if (f) begin
            if (m_ia < DW) exp_d[m_ia] = ~d[m_ia];
            if (m_dbl && m_ib < DW) exp_d[m_ib] = ~d[m_ib];
        end
        case (a)
            2'd0: exp_r = {29'd0, m_dbl, m_per, m_en};
            2'd1: exp_r = {16'd0, 8'(m_ib), 8'(m_ia)};
            2'd2: exp_r = 32'(m_ivl);
            default: exp_r = (32'(m_cnt) << 16) | {30'd0, m_armed, m_done};
        endcase
        chk(tag, "out_data", 128'(out_data), 128'(exp_d));
        chk(tag, "out_valid", 128'(out_valid), 128'(v));
        chk(tag, "inj_fire", 128'(inj_fire), 128'(f));
        chk(tag, "cfg_rdata", 128'(cfg_rdata), 128'(exp_r));
        @(posedge clk);
        if (we && a == 2'd0) begin
            m_en = wd[0]; m_per = wd[1]; m_dbl = wd[2];
            m_armed = wd[0] && !wd[1]; m_gap = 0; m_done = 0;
        end else begin
            if (f && !m_per) begin m_armed = 0; m_done = 1; end
            if (v && m_en && m_per) m_gap = f ? 0 : m_gap + 1;
        end
        if (we && a == 2'd3) begin m_cnt = 0; m_done = 0; end
        else if (f && m_cnt < CMAX) m_cnt++;
        if (we && a == 2'd1) begin m_ia = int'(wd[7:0]); m_ib = int'(wd[15:8]); end
        if (we && a == 2'd2) m_ivl = int'(wd[IW-1:0]);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] wd, string tag);
        step(1'b0, 1'b1, a, wd, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: reset state on every register and on the data path
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 2'(k), '0, "R1");
        // R2: clean pass-through with mixed valid
        for (int k = 0; k < 10; k++) step(k[0], 1'b0, 2'd3, '0, "R2");
        // R10: write and read back SEL and INTERVAL
        wr(2'd1, 32'h0000_4605, "R10");
        wr(2'd2, 32'h0000_0003, "R10");
        step(1'b0, 1'b0, 2'd1, '0, "R10");
        step(1'b0, 1'b0, 2'd2, '0, "R10");
        // R3: one-shot; idle cycles first must stay clean (R2)
        wr(2'd0, 32'h1, "R3");
        step(1'b0, 1'b0, 2'd3, '0, "R3");
        for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 2'd3, '0, "R2");
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 2'd3, '0, "R3");
        step(1'b0, 1'b0, 2'd0, '0, "R10");
        // R8: index beyond the word
        wr(2'd1, 32'h0000_0064, "R8");
        wr(2'd0, 32'h1, "R8");
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 2'd3, '0, "R8");
        // R7: two bits, then equal indices
        wr(2'd1, 32'h0000_4003, "R7");
        wr(2'd0, 32'h5, "R7");
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 2'd3, '0, "R7");
        wr(2'd1, 32'h0000_0909, "R7");
        wr(2'd0, 32'h5, "R7");
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 2'd3, '0, "R7");
        // R4: periodic with interval 3 and gaps in valid
        wr(2'd1, 32'h0000_0047, "R4");
        wr(2'd3, 32'h0, "R9");
        wr(2'd0, 32'h3, "R4");
        for (int k = 0; k < 24; k++) step((k % 3) != 1, 1'b0, 2'd3, '0, "R4");
        // R11: periodic double flip on interval 1
        wr(2'd2, 32'h1, "R11");
        wr(2'd0, 32'h7, "R11");
        for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 2'd3, '0, "R11");
        // R5: interval zero hits every valid word
        wr(2'd2, 32'h0, "R5");
        wr(2'd0, 32'h3, "R5");
        for (int k = 0; k < 6; k++) step(k != 2, 1'b0, 2'd3, '0, "R5");
        // R6: disable stops injections
        wr(2'd0, 32'h2, "R6");
        for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 2'd3, '0, "R6");
        // R9: saturation then clear
        wr(2'd3, 32'h0, "R9");
        wr(2'd0, 32'h3, "R9");
        for (int k = 0; k < 20; k++) step(1'b1, 1'b0, 2'd3, '0, "R9");
        wr(2'd0, 32'h0, "R9");
        wr(2'd3, 32'h0, "R9");
        step(1'b0, 1'b0, 2'd3, '0, "R9");
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule